// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 16-bit unsigned adder that takes two operands and a carry input and returns a 16-bit sum and a carry output. It is meant for datapaths where the carry chain of a simple adder would set the critical path. The operands are split into four 4-bit groups, and no carry ever ripples from one bit to the next or from one group to the next.

All bit generate (a AND b) and bit propagate (a XOR b) terms are formed at once. Each group turns them into its internal carries through flattened sum-of-products equations. Each group also reports a group generate and a group propagate. A second lookahead level combines the four group pairs with the carry input and produces the carry into every group, and the final carry, in parallel. Each sum bit is its propagate term XOR the carry into that bit.

Top module: `cla16_adder`

## Requirements
- R1: For every a, b and cin, the 17-bit value {cout, sum} equals the unsigned sum a + b + cin.
- R2: A carry generated in the lowest group travels through every higher group whose bits all propagate: 0xFFFF + 0x0001 with cin = 0 gives sum 0x0000 and cout 1.
- R3: The carry input alone crosses all four groups when every bit propagates: 0xFFFF + 0x0000 with cin = 1 gives sum 0x0000 and cout 1.
- R4: A carry generated inside one group enters the next group at its lowest bit: 0x000F + 0x0001 gives 0x0010, 0x00F0 + 0x0010 gives 0x0100, and 0x0FFF + 0x0001 gives 0x1000.
- R5: When every bit propagates and none generates (a XOR b = 0xFFFF), the sum is 0xFFFF with cout 0 for cin = 0, and 0x0000 with cout 1 for cin = 1.
- R6: cout is 1 exactly when a + b + cin exceeds 0xFFFF. A generate in the top bit alone sets it: 0x8000 + 0x8000 gives sum 0 and cout 1, while 0x7FFF + 0x0001 gives 0x8000 and cout 0.
- R7: A group whose propagate is set passes its carry input unchanged to the next group, and a group whose generate is set always sends a carry to the next group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand, unsigned |
| b | input | 16 | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The bench targets the carry paths that only the second lookahead level can serve. These are a carry born in group 0 that must cross three all-propagate groups, and a carry input that must cross the whole word. A design that rippled wrongly, or that dropped a term of a flattened product, would return a nonzero sum or a missing cout on 0xFFFF + 1. Group-boundary cases such as 0x000F + 1 and 0x00F0 + 0x10 expose a carry sent to the wrong group. The alternating 0x5555 / 0xAAAA pair, with and without cin, catches a propagate term mistaken for a generate. Random operands compared against plain integer addition cover the remaining mixes of generate, propagate and kill.

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int GROUPS = 4,
  localparam int GW = 4,
  localparam int WIDTH = GROUPS * GW
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  function automatic logic [GW:0] bit_look(input logic [GW-1:0] g, input logic [GW-1:0] p,
                                           input logic ci);
    logic [GW:0] c;
    logic term;
    c[0] = ci;
    for (int i = 0; i < GW; i++) begin
      c[i+1] = 1'b0;
      for (int j = 0; j <= i; j++) begin
        term = g[j];
        for (int k = j + 1; k <= i; k++) term = term & p[k];
        c[i+1] = c[i+1] | term;
      end
      term = ci;
      for (int k = 0; k <= i; k++) term = term & p[k];
      c[i+1] = c[i+1] | term;
    end
    return c;
  endfunction

  function automatic logic [GROUPS:0] grp_look(input logic [GROUPS-1:0] g,
                                               input logic [GROUPS-1:0] p, input logic ci);
    logic [GROUPS:0] c;
    logic term;
    c[0] = ci;
    for (int i = 0; i < GROUPS; i++) begin
      c[i+1] = 1'b0;
      for (int j = 0; j <= i; j++) begin
        term = g[j];
        for (int k = j + 1; k <= i; k++) term = term & p[k];
        c[i+1] = c[i+1] | term;
      end
      term = ci;
      for (int k = 0; k <= i; k++) term = term & p[k];
      c[i+1] = c[i+1] | term;
    end
    return c;
  endfunction

  logic [WIDTH-1:0]  gen_b, prop_b, carry_b;
  logic [GROUPS-1:0] gen_g, prop_g;
  logic [GROUPS:0]   carry_g;

  assign gen_b  = a & b;
  assign prop_b = a ^ b;

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_grp
    logic [GW-1:0] gg_b, pp_b;
    logic [GW:0]   inner, gen_only;
    assign gg_b     = gen_b[gi*GW +: GW];
    assign pp_b     = prop_b[gi*GW +: GW];
    assign gen_only = bit_look(gg_b, pp_b, 1'b0);
    assign gen_g[gi]  = gen_only[GW];
    assign prop_g[gi] = &pp_b;
    assign inner    = bit_look(gg_b, pp_b, carry_g[gi]);
    assign carry_b[gi*GW +: GW] = inner[GW-1:0];

    always_comb begin
      // R7
      grp_pass_chk: assert (!(prop_g[gi] == 1'b1 && inner[GW] != carry_g[gi]));
      // R7
      grp_gen_chk: assert (!(gen_g[gi] == 1'b1 && carry_g[gi+1] != 1'b1));
      // R7
      grp_next_chk: assert (inner[GW] == carry_g[gi+1]);
    end
  end

  assign carry_g = grp_look(gen_g, prop_g, cin);
  assign sum     = prop_b ^ carry_b;
  assign cout    = carry_g[GROUPS];

  always_comb begin
    // R1
    total_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
    // R5
    all_prop_chk: assert (!((a ^ b) == {WIDTH{1'b1}} && cout != cin));
  end

endmodule

// File: tb/cla16_adder_tb.sv
module cla16_adder_tb;
  localparam int W = 16;
  localparam int NV = 14;
  localparam int NRAND = 3000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic cin, cout;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  cla16_adder u_dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  // {a, b, cin, expected sum, expected cout}
  localparam logic [49:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
    {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},
    {16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0},
    {16'h00F0, 16'h0010, 1'b0, 16'h0100, 1'b0},
    {16'h0FFF, 16'h0001, 1'b0, 16'h1000, 1'b0},
    {16'h5555, 16'hAAAA, 1'b0, 16'hFFFF, 1'b0},
    {16'h5555, 16'hAAAA, 1'b1, 16'h0000, 1'b1},
    {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1},
    {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0},
    {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},
    {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},
    {16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0},
    {16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0}
  };

  function automatic string tag_of(input int i);
    case (i)
      1: return "R2";
      2: return "R3";
      3, 4, 5, 13: return "R4";
      6, 7: return "R5";
      8, 9, 11: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc);
    @(negedge clk);
    a = ta; b = tb; cin = tc;
    #2;
  endtask

  task automatic check(input string tag, input logic [W-1:0] es, input logic ec);
    total++;
    if (sum !== es || cout !== ec) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%b got sum=%h cout=%b exp sum=%h cout=%b",
               tag, a, b, cin, sum, cout, es, ec);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    // R1: idle inputs give a zero result
    apply('0, '0, 1'b0);
    check("R1", 16'h0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
      check(tag_of(i), VEC[i][16:1], VEC[i][0]);
    end

    // R7: a carry entering an all-propagate group leaves it unchanged (group 2 here)
    apply(16'h0F80, 16'h0080, 1'b0);
    check("R7", 16'h1000, 1'b0);
    // R7: generate in group 1 feeds group 2 regardless of group 0
    apply(16'h0080, 16'h0080, 1'b1);
    check("R7", 16'h0101, 1'b0);

    // R6: cout flips at the 0xFFFF boundary
    apply(16'hFFFE, 16'h0000, 1'b1);
    check("R6", 16'hFFFF, 1'b0);

    for (int n = 0; n < NRAND; n++) begin
      logic [W-1:0] ra, rb;
      logic rc;
      logic [W:0] ex;
      ra = W'($urandom);
      rb = W'($urandom);
      rc = 1'($urandom);
      ex = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
      apply(ra, rb, rc);
      check("R1", ex[W-1:0], ex[W]);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule